// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the command front end of a parallel NOR-style flash memory. It watches single-cycle bus write strobes, each carrying an address and a 16-bit data word, and interprets the low data byte as part of a command language. In that language the meaning of a write depends on the writes before it. Single-cycle commands set the read mode (array, identifier, query table or status), clear the status error bit, or request suspend and resume. Two-cycle and multi-cycle commands end in a one-cycle start pulse to a separate array controller. The pulse carries an operation code, the target address and a data word.

The opcode 0x60 is a shared prefix, and the second byte written after it selects block lock, unlock, lock-down or a configuration load. Buffered programming takes a word count, then exactly that many data words, then a confirm byte. Each data word is streamed out on a write-buffer port together with its index. Every write after the first one in a sequence must fall inside the block addressed by the first write. A wrong follow-on byte or a write to a different block aborts the sequence and raises a sequence-error flag.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, read_mode is 0 and seq_err is 0. A single write with low byte 0xFF, 0x90, 0x98 or 0x70 sets read_mode to 0 (array), 1 (identifier), 2 (query) or 3 (status) respectively. Only bits [7:0] of wr_data are decoded as a command byte, and every output is registered and visible one clock after the write.
- R2: A single write of 0x50 gives a one-cycle clr_status pulse, clears seq_err and leaves read_mode unchanged.
- R3: A write of 0x40 followed by any write to the same block gives op_start with op_code 1. op_addr is the address of the first write and op_data is the data of the second write.
- R4: A write of 0x20 followed by 0xD0 to the same block gives op_start with op_code 2. Any other second byte is a sequence error.
- R5: A write of 0xE8 followed by a count word C, where C is at most 255, then exactly C+1 data writes and then 0xD0, gives op_start with op_code 3 and op_data equal to C. Data write k (starting at 0) gives a buf_we pulse with buf_idx equal to k and buf_data equal to its data. A count word above 255 is a sequence error.
- R6: After the prefix 0x60, a second byte of 0x01, 0xD0, 0x2F or 0x03 gives op_code 4 (lock), 5 (unlock), 6 (lock-down) or 7 (configure) respectively. For configure, op_data is the second write's address and no block check is made. Any other second byte is a sequence error.
- R7: 0xC0 followed by any data write gives op_code 8 with that data. 0xBC followed by 0xD0 gives op_code 9. 0x80 followed by 0xD0 gives op_code 10.
- R8: A first-cycle write of 0xB0 gives a one-cycle suspend_req pulse, and a first-cycle write of 0xD0 gives a one-cycle resume_req pulse. Neither pulse changes read_mode.
- R9: An unexpected second or confirm byte sets seq_err and sets read_mode to 3, with no op_start.
- R10: A later write in a sequence whose address bits above the block offset (bits [15:8] by default) differ from those of the first write is a sequence error.
- R11: Whenever op_start is issued, read_mode becomes 3 in the same cycle.
- R12: While ctl_busy is high, only 0x70 (status read) and 0xB0 (suspend) have any effect, and all other writes are ignored.
- R13: A first-cycle byte that is not a known command leaves every output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | AW | Write address |
| wr_data | input | 16 | Write data; command byte in [7:0] |
| ctl_busy | input | 1 | Array controller is running an operation |
| read_mode | output | 2 | 0 array, 1 identifier, 2 query, 3 status |
| seq_err | output | 1 | Command-sequence error flag |
| op_start | output | 1 | One-cycle start pulse to the array controller |
| op_code | output | 4 | Operation selector (see R3 to R7) |
| op_addr | output | AW | Target address (first write of the sequence) |
| op_data | output | 16 | Word data, count or configuration value |
| buf_we | output | 1 | Write-buffer load strobe |
| buf_idx | output | CNT_W | Write-buffer word index |
| buf_data | output | 16 | Write-buffer word |
| suspend_req | output | 1 | Suspend request pulse |
| resume_req | output | 1 | Resume request pulse |
| clr_status | output | 1 | Status clear pulse |

## Verification
Every one of the 256 first-cycle bytes is tried from array mode, which separates read-mode commands, pulse commands, sequence starters and ignored values. Every sequence starter is then closed by a write to a foreign block, which checks the block guard. The second byte after the 0x60 prefix and after the erase opcode is swept over all 256 values, so that each valid sub-opcode is told apart from its rejected neighbours. Buffered programs run with counts of 1, 2, 3, 17 and 256 words, which covers both ends of the index range, and also with an oversize count and a wrong confirm byte. A busy window shows that a blocked program sequence and blocked mode changes are dropped, while the status read and the suspend request still get through.

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int AW    = 16,
  parameter int BLK_W = 8,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [15:0]      wr_data,
  input  logic             ctl_busy,
  output logic [1:0]       read_mode,
  output logic             seq_err,
  output logic             op_start,
  output logic [3:0]       op_code,
  output logic [AW-1:0]    op_addr,
  output logic [15:0]      op_data,
  output logic             buf_we,
  output logic [CNT_W-1:0] buf_idx,
  output logic [15:0]      buf_data,
  output logic             suspend_req,
  output logic             resume_req,
  output logic             clr_status
);

  localparam logic [15:0] CNT_MAX = 16'((1 << CNT_W) - 1);
  localparam logic [1:0]  M_ARR = 2'd0, M_ID = 2'd1, M_QRY = 2'd2, M_STAT = 2'd3;

  typedef enum logic [3:0] {
    S_IDLE, S_PROG, S_ERASE, S_PFX, S_REG, S_BLANK, S_FACT, S_BCNT, S_BDATA, S_BCONF
  } st_t;

  st_t              st;
  logic [AW-1:0]    base;
  logic [CNT_W-1:0] cnt, wcnt;

  wire [7:0] cb       = wr_data[7:0];
  wire       same_blk = wr_addr[AW-1:BLK_W] == base[AW-1:BLK_W];
  wire       is_cnf   = cb == 8'hD0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      base        <= '0;
      cnt         <= '0;
      wcnt        <= '0;
      read_mode   <= M_ARR;
      seq_err     <= 1'b0;
      op_start    <= 1'b0;
      op_code     <= '0;
      op_addr     <= '0;
      op_data     <= '0;
      buf_we      <= 1'b0;
      buf_idx     <= '0;
      buf_data    <= '0;
      suspend_req <= 1'b0;
      resume_req  <= 1'b0;
      clr_status  <= 1'b0;
    end else begin
      op_start    <= 1'b0;
      buf_we      <= 1'b0;
      suspend_req <= 1'b0;
      resume_req  <= 1'b0;
      clr_status  <= 1'b0;
      if (wr_en && ctl_busy) begin
        if (cb == 8'h70) read_mode <= M_STAT;
        if (cb == 8'hB0) suspend_req <= 1'b1;
      end else if (wr_en) begin
        st <= S_IDLE;
        case (st)
          S_IDLE: begin
            base <= wr_addr;
            case (cb)
              8'hFF: read_mode <= M_ARR;
              8'h90: read_mode <= M_ID;
              8'h98: read_mode <= M_QRY;
              8'h70: read_mode <= M_STAT;
              8'h50: begin seq_err <= 1'b0; clr_status <= 1'b1; end
              8'hB0: suspend_req <= 1'b1;
              8'hD0: resume_req <= 1'b1;
              8'h40: st <= S_PROG;
              8'h20: st <= S_ERASE;
              8'h60: st <= S_PFX;
              8'hC0: st <= S_REG;
              8'hBC: st <= S_BLANK;
              8'h80: st <= S_FACT;
              8'hE8: st <= S_BCNT;
              default: ;
            endcase
          end
          S_PFX: begin
            if (cb == 8'h03) begin
              op_start  <= 1'b1;
              op_code   <= 4'd7;
              op_addr   <= base;
              op_data   <= 16'(wr_addr);
              read_mode <= M_STAT;
            end else if (same_blk && (cb == 8'h01 || cb == 8'hD0 || cb == 8'h2F)) begin
              op_start  <= 1'b1;
              op_code   <= (cb == 8'h01) ? 4'd4 : (cb == 8'hD0) ? 4'd5 : 4'd6;
              op_addr   <= base;
              op_data   <= wr_data;
              read_mode <= M_STAT;
            end else begin
              seq_err   <= 1'b1;
              read_mode <= M_STAT;
            end
          end
          S_PROG, S_REG, S_ERASE, S_BLANK, S_FACT: begin
            if (same_blk && (st == S_PROG || st == S_REG || is_cnf)) begin
              op_start  <= 1'b1;
              op_code   <= (st == S_PROG) ? 4'd1 : (st == S_REG) ? 4'd8 :
                           (st == S_ERASE) ? 4'd2 : (st == S_BLANK) ? 4'd9 : 4'd10;
              op_addr   <= base;
              op_data   <= wr_data;
              read_mode <= M_STAT;
            end else begin
              seq_err   <= 1'b1;
              read_mode <= M_STAT;
            end
          end
          S_BCNT: begin
            if (same_blk && wr_data <= CNT_MAX) begin
              cnt  <= wr_data[CNT_W-1:0];
              wcnt <= '0;
              st   <= S_BDATA;
            end else begin
              seq_err   <= 1'b1;
              read_mode <= M_STAT;
            end
          end
          S_BDATA: begin
            if (same_blk) begin
              buf_we   <= 1'b1;
              buf_idx  <= wcnt;
              buf_data <= wr_data;
              wcnt     <= wcnt + 1'b1;
              st       <= (wcnt == cnt) ? S_BCONF : S_BDATA;
            end else begin
              seq_err   <= 1'b1;
              read_mode <= M_STAT;
            end
          end
          S_BCONF: begin
            if (same_blk && is_cnf) begin
              op_start  <= 1'b1;
              op_code   <= 4'd3;
              op_addr   <= base;
              op_data   <= 16'(cnt);
              read_mode <= M_STAT;
            end else begin
              seq_err   <= 1'b1;
              read_mode <= M_STAT;
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [15:0] wr_data,
  input logic        ctl_busy,
  input logic [1:0]  read_mode,
  input logic        seq_err,
  input logic        op_start,
  input logic        buf_we,
  input logic        suspend_req,
  input logic        resume_req,
  input logic        clr_status
);

  p_single_action_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({op_start, buf_we, suspend_req, resume_req, clr_status}));

  p_start_status_r11: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |-> read_mode == 2'd3);

  p_err_no_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seq_err) |-> !op_start && read_mode == 2'd3);

  p_clear_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clr_status |-> !seq_err);

  p_busy_ignore_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_busy && wr_en && wr_data[7:0] != 8'h70 && wr_data[7:0] != 8'hB0) |=>
      !op_start && !buf_we && !resume_req && !clr_status &&
      $stable(read_mode) && $stable(seq_err));

endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .ctl_busy(ctl_busy),
  .read_mode(read_mode), .seq_err(seq_err), .op_start(op_start), .buf_we(buf_we),
  .suspend_req(suspend_req), .resume_req(resume_req), .clr_status(clr_status)
);

// File: tb/sim_flash_cmd_decoder.sv
module sim_flash_cmd_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        ctl_busy = 1'b0;
  logic [1:0]  read_mode;
  logic        seq_err, op_start, buf_we, suspend_req, resume_req, clr_status;
  logic [3:0]  op_code;
  logic [15:0] op_addr, op_data, buf_data;
  logic [7:0]  buf_idx;

  int checks = 0;
  int errors = 0;
  localparam logic [15:0] BLK_A = 16'h1200, BLK_B = 16'h3400;

  always #2 clk = ~clk;

  flash_cmd_decoder u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ctl_busy(ctl_busy), .read_mode(read_mode), .seq_err(seq_err), .op_start(op_start),
    .op_code(op_code), .op_addr(op_addr), .op_data(op_data), .buf_we(buf_we),
    .buf_idx(buf_idx), .buf_data(buf_data), .suspend_req(suspend_req),
    .resume_req(resume_req), .clr_status(clr_status)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
  endtask

  task automatic expect_op(input string tag, input int code, input int addr, input int data);
    chk({tag, " op_start"}, int'(op_start), 1);
    chk({tag, " op_code"}, int'(op_code), code);
    chk({tag, " op_addr"}, int'(op_addr), addr);
    chk({tag, " op_data"}, int'(op_data), data);
    chk({tag, " R11 mode"}, int'(read_mode), 3);
  endtask

  task automatic expect_err(input string tag);
    chk({tag, " R9 seq_err"}, int'(seq_err), 1);
    chk({tag, " R9 no start"}, int'(op_start), 0);
    chk({tag, " R9 mode"}, int'(read_mode), 3);
  endtask

  task automatic clear_err();
    wr(BLK_A, 16'h0050);
  endtask

  task automatic buffered(input int n, input bit good_conf);
    wr(BLK_A + 16'h10, 16'h00E8);
    wr(BLK_A, 16'(n - 1));
    for (int k = 0; k < n; k++) begin
      wr(BLK_A + 16'(k & 8'hFF), 16'(k * 7 + n));
      chk("R5 buf_we", int'(buf_we), 1);
      chk("R5 buf_idx", int'(buf_idx), k);
      chk("R5 buf_data", int'(buf_data), (k * 7 + n) & 16'hFFFF);
    end
    if (good_conf) begin
      wr(BLK_A, 16'h00D0);
      expect_op("R5 buffered", 3, BLK_A + 16'h10, n - 1);
    end else begin
      wr(BLK_A, 16'h00D1);
      expect_err("R5 bad confirm");
      clear_err();
    end
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    chk("R1 reset mode", int'(read_mode), 0);
    chk("R1 reset seq_err", int'(seq_err), 0);
    chk("R1 reset op_start", int'(op_start), 0);

    for (int b = 0; b < 256; b++) begin
      int em;
      bit multi;
      wr(BLK_A, 16'h00FF);
      wr(BLK_A, 16'h5A00 | 16'(b));
      case (b)
        8'h90: em = 1; 8'h98: em = 2; 8'h70: em = 3; default: em = 0;
      endcase
      multi = (b == 8'h40 || b == 8'h20 || b == 8'h60 || b == 8'hC0 ||
               b == 8'hBC || b == 8'h80 || b == 8'hE8);
      chk("R1 R13 mode", int'(read_mode), em);
      chk("R13 no start", int'(op_start), 0);
      chk("R13 seq_err", int'(seq_err), 0);
      chk("R8 suspend", int'(suspend_req), int'(b == 8'hB0));
      chk("R8 resume", int'(resume_req), int'(b == 8'hD0));
      chk("R2 clr", int'(clr_status), int'(b == 8'h50));
      if (multi) begin
        wr(BLK_B, 16'h00D0);
        expect_err("R10 foreign block");
        clear_err();
        chk("R2 cleared", int'(seq_err), 0);
        chk("R2 mode kept", int'(read_mode), 3);
      end
    end

    for (int s = 0; s < 256; s++) begin
      int code;
      wr(BLK_A, 16'h0060);
      wr(BLK_A + 16'h3, 16'h0100 | 16'(s));
      case (s)
        8'h01: code = 4; 8'hD0: code = 5; 8'h2F: code = 6; 8'h03: code = 7; default: code = 0;
      endcase
      if (code == 7) expect_op("R6 configure", 7, BLK_A, BLK_A + 3);
      else if (code != 0) expect_op("R6 lock", code, BLK_A, 16'h0100 | s);
      else begin expect_err("R6 bad sub"); clear_err(); end
    end
    wr(BLK_A, 16'h0060);
    wr(BLK_B + 16'h77, 16'h0003);
    expect_op("R6 configure no blk check", 7, BLK_A, BLK_B + 16'h77);

    for (int s = 0; s < 256; s++) begin
      wr(BLK_A + 16'h44, 16'h0020);
      wr(BLK_A + 16'h9, 16'(s));
      if (s == 8'hD0) expect_op("R4 erase", 2, BLK_A + 16'h44, 16'h00D0);
      else begin expect_err("R4 bad confirm"); clear_err(); end
    end

    wr(BLK_A + 16'h21, 16'h0040);
    wr(BLK_A + 16'h22, 16'hBEEF);
    expect_op("R3 word program", 1, BLK_A + 16'h21, 16'hBEEF);
    wr(BLK_A + 16'h5, 16'h00C0);
    wr(BLK_A + 16'h5, 16'h1357);
    expect_op("R7 register program", 8, BLK_A + 16'h5, 16'h1357);
    wr(BLK_A, 16'h00BC);
    wr(BLK_A, 16'h00D0);
    expect_op("R7 blank check", 9, BLK_A, 16'h00D0);
    wr(BLK_A + 16'h8, 16'h0080);
    wr(BLK_A + 16'h8, 16'h00D0);
    expect_op("R7 factory", 10, BLK_A + 16'h8, 16'h00D0);
    wr(BLK_A, 16'h00BC);
    wr(BLK_A, 16'h00D1);
    expect_err("R7 blank bad");
    clear_err();

    buffered(1, 1'b1);
    buffered(2, 1'b1);
    buffered(3, 1'b0);
    buffered(17, 1'b1);
    buffered(256, 1'b1);
    wr(BLK_A, 16'h00E8);
    wr(BLK_A, 16'h0100);
    expect_err("R5 count too big");
    clear_err();
    wr(BLK_A, 16'h00E8);
    wr(BLK_A, 16'h0002);
    wr(BLK_A, 16'h0001);
    wr(BLK_B, 16'h0002);
    expect_err("R10 buffer data block");
    chk("R10 no buf_we", int'(buf_we), 0);
    clear_err();

    wr(BLK_A, 16'h00FF);
    ctl_busy = 1'b1;
    wr(BLK_A, 16'h0090);
    chk("R12 busy mode kept", int'(read_mode), 0);
    wr(BLK_A, 16'h0040);
    wr(BLK_A, 16'h4321);
    chk("R12 busy no start", int'(op_start), 0);
    wr(BLK_A, 16'h0050);
    chk("R12 busy no clr", int'(clr_status), 0);
    wr(BLK_A, 16'h00D0);
    chk("R12 busy no resume", int'(resume_req), 0);
    wr(BLK_A, 16'h0070);
    chk("R12 busy status", int'(read_mode), 3);
    wr(BLK_A, 16'h00FF);
    chk("R12 busy keep status", int'(read_mode), 3);
    wr(BLK_A, 16'h00B0);
    chk("R12 R8 busy suspend", int'(suspend_req), 1);
    ctl_busy = 1'b0;
    wr(BLK_A, 16'h0098);
    chk("R1 query after busy", int'(read_mode), 2);
    chk("R8 pulse width", int'(suspend_req), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule